// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Direction Control

This block is a small general-purpose I/O port with four pins. Three of the pins can each be an input or an output. The top pin is an input only. For each output-capable pin, a data latch supplies the value driven to the pad and a direction latch decides whether the pad driver is on. Software reaches the block over a plain strobe bus. One write strobe and one read strobe serve the data register, and a second pair serves the direction register.

A port read returns what the pads carry, not what the latch holds. Each pad input passes through a two-flop synchronizer before it reaches the read selector. A per-pin analog-select input forces the read-back of pins 0 to 2 to zero, but it never changes what the driver does. A reset-pin-enable input gives the top pin to a reset function; while it is high, that bit reads as zero. Reads are registered: a strobe loads the read-data register at the clock edge, and the register keeps its value until the next strobe.

Top module: `quad_io_port`

## Requirements
- R1: While rst is high, every direction latch is set to 1 (input) and every data latch is cleared to 0. Both synchronizer stages and the read-data register are cleared. After reset, pad_oe is 4'b0000 and a direction read returns 8'h0F.
- R2: For pins 0 to 2, pad_oe[i] is the inverse of that pin's direction latch, where 1 means input and 0 means output. pad_oe[3] is always 0.
- R3: A clock edge with dat_wr high loads bus_wdata[2:0] into the data latches. Bits 7 to 3 of the write are ignored. pad_out[2:0] follows the latches and pad_out[3] is always 0. Without dat_wr, the latches hold their values.
- R4: Each pad input crosses two synchronizer flops. A pad value first becomes stable just before edge k. A data read strobed at edge k+1 still returns the earlier value, and a data read strobed at edge k+2 returns the new value.
- R5: A clock edge with dat_rd high loads bus_rdata with the port value in bits 3:0 and zeros in bits 7:4. With dir_rd high and dat_rd low, the edge loads the direction value instead. When both strobes are high, the data read wins. With neither strobe high, bus_rdata holds its value.
- R6: For a pin i in 0 to 2, ana_sel[i]=1 makes bit i of a data read return 0, whatever the pad carries.
- R7: Bit 3 of a direction read is always 1. Writes to bit 3 of the direction register have no effect.
- R8: While rst_pin_en is 1, bit 3 of a data read is 0. While rst_pin_en is 0, bit 3 returns the synchronized pad_in[3].
- R9: ana_sel has no effect on pad_oe or pad_out.
- R10: A clock edge with dir_wr high loads bus_wdata[2:0] into the direction latches. A direction read returns {4'b0000, 1'b1, dir[2:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wdata | input | 8 | Write data for either register |
| dat_wr | input | 1 | Data register write strobe |
| dat_rd | input | 1 | Data register read strobe |
| dir_wr | input | 1 | Direction register write strobe |
| dir_rd | input | 1 | Direction register read strobe |
| bus_rdata | output | 8 | Registered read data |
| ana_sel | input | 3 | Analog select for pins 0 to 2 |
| rst_pin_en | input | 1 | Top pin used as reset input |
| pad_in | input | 4 | Values seen at the pads |
| pad_oe | output | 4 | Pad driver enables |
| pad_out | output | 4 | Pad driver values |

## Verification
The bench builds the block with its default parameters: four pins, an 8-bit bus and two synchronizer stages. With these values, every mix of analog selects and the reset-pin enable can be visited during the random phase. The two-stage latency also makes the cycle in which a new pad value first reaches a read a short, explicit check. The 8-bit bus leaves four unused upper bits, which lets the bench confirm that they read as zero and that writes to them are ignored.

// File: rtl/qport_pkg.sv
package qport_pkg;

    parameter int unsigned QP_PINS   = 4;
    parameter int unsigned QP_BUS_W  = 8;
    parameter int unsigned QP_SYNC   = 2;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_DATA = 2'd1,
        RSEL_DIR  = 2'd2
    } rsel_e;

    // A data read takes priority over a direction read.
    function automatic rsel_e pick_read(input logic want_dat, input logic want_dir);
        if (want_dat)
            return RSEL_DATA;
        else if (want_dir)
            return RSEL_DIR;
        else
            return RSEL_NONE;
    endfunction

endpackage

// File: rtl/qport_sync.sv
module qport_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++)
                stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

    AST_SYNC_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)) else $error("sync not cleared"); // R1
endmodule

// File: rtl/qport_pin.sv
module qport_pin (
    input  logic clk,
    input  logic rst,
    input  logic wr_dat,
    input  logic wr_dir,
    input  logic wbit,
    output logic lat_q,
    output logic dir_q,
    output logic oe,
    output logic out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
            dir_q <= 1'b1;
        end else begin
            if (wr_dat) lat_q <= wbit;
            if (wr_dir) dir_q <= wbit;
        end
    end

    assign oe  = ~dir_q;
    assign out = lat_q;

    AST_DAT_LOAD: assert property (@(posedge clk) disable iff (rst) wr_dat |=> (lat_q == $past(wbit))) else $error("latch load"); // R3
    AST_DAT_KEEP: assert property (@(posedge clk) disable iff (rst) !wr_dat |=> $stable(lat_q)) else $error("latch hold"); // R3
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst) wr_dir |=> (dir_q == $past(wbit))) else $error("dir load"); // R10
endmodule

// File: rtl/qport_rmux.sv
module qport_rmux
    import qport_pkg::*;
#(
    parameter int unsigned NPINS = 4,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  rsel_e            sel,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-2:0] ana_sel,
    input  logic             rst_pin_en,
    input  logic [NPINS-2:0] dir_bits,
    output logic [BUS_W-1:0] rdata
);
    localparam int unsigned TOP = NPINS - 1;

    logic [NPINS-1:0] port_val;
    logic [NPINS-1:0] dir_val;

    always_comb begin
        port_val[TOP-1:0] = sync_in[TOP-1:0] & ~ana_sel;
        port_val[TOP]     = sync_in[TOP] & ~rst_pin_en;
        dir_val           = {1'b1, dir_bits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            case (sel)
                RSEL_DATA: rdata <= BUS_W'(port_val);
                RSEL_DIR:  rdata <= BUS_W'(dir_val);
                default:   rdata <= rdata;
            endcase
        end
    end

    AST_RD_HOLD:    assert property (@(posedge clk) disable iff (rst) (sel == RSEL_NONE) |=> $stable(rdata)) else $error("rdata hold"); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (sel != RSEL_NONE) |=> ((rdata >> NPINS) == '0)) else $error("upper bits"); // R5
    AST_DIR_TOP:    assert property (@(posedge clk) disable iff (rst) (sel == RSEL_DIR) |=> rdata[TOP]) else $error("dir top bit"); // R7
    AST_ANA_ZERO:   assert property (@(posedge clk) disable iff (rst) (sel == RSEL_DATA) |=> ((rdata[TOP-1:0] & $past(ana_sel)) == '0)) else $error("analog read"); // R6
    AST_RPE_ZERO:   assert property (@(posedge clk) disable iff (rst) (sel == RSEL_DATA && rst_pin_en) |=> !rdata[TOP]) else $error("reset pin read"); // R8
endmodule

// File: rtl/quad_io_port.sv
module quad_io_port
    import qport_pkg::*;
#(
    parameter int unsigned NPINS  = QP_PINS,
    parameter int unsigned BUS_W  = QP_BUS_W,
    parameter int unsigned SYNC_N = QP_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic             dir_wr,
    input  logic             dir_rd,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-2:0] ana_sel,
    input  logic             rst_pin_en,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);
    localparam int unsigned NIO = NPINS - 1;

    logic [NIO-1:0]   lat_bits;
    logic [NIO-1:0]   dir_bits;
    logic [NPINS-1:0] pad_sync;
    rsel_e            rsel;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[BUS_W-1:NIO] ^ ^lat_bits;

    for (genvar i = 0; i < NIO; i++) begin : g_pin
        qport_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .wr_dat (dat_wr),
            .wr_dir (dir_wr),
            .wbit   (bus_wdata[i]),
            .lat_q  (lat_bits[i]),
            .dir_q  (dir_bits[i]),
            .oe     (pad_oe[i]),
            .out    (pad_out[i])
        );
    end

    // Input-only top pin never drives.
    assign pad_oe[NIO]  = 1'b0;
    assign pad_out[NIO] = 1'b0;

    qport_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    assign rsel = pick_read(dat_rd, dir_rd);

    qport_rmux #(.NPINS(NPINS), .BUS_W(BUS_W)) u_rmux (
        .clk        (clk),
        .rst        (rst),
        .sel        (rsel),
        .sync_in    (pad_sync),
        .ana_sel    (ana_sel),
        .rst_pin_en (rst_pin_en),
        .dir_bits   (dir_bits),
        .rdata      (bus_rdata)
    );

    AST_RESET_DIR: assert property (@(posedge clk) rst |=> (pad_oe == '0)) else $error("reset direction"); // R1
    AST_ANA_NO_OE: assert property (@(posedge clk) disable iff (rst) (!dir_wr && $changed(ana_sel)) |=> $stable(pad_oe)) else $error("analog touched oe"); // R9
endmodule

// File: tb/quad_io_port_bench.sv
module quad_io_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic       dat_wr = 0, dat_rd = 0, dir_wr = 0, dir_rd = 0;
    logic [7:0] bus_rdata;
    logic [2:0] ana_sel = '0;
    logic       rst_pin_en = 0;
    logic [3:0] pad_in = '0;
    logic [3:0] pad_oe, pad_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    quad_io_port u_quad_io_port (
        .clk(clk), .rst(rst), .bus_wdata(bus_wdata),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dir_wr(dir_wr), .dir_rd(dir_rd),
        .bus_rdata(bus_rdata), .ana_sel(ana_sel), .rst_pin_en(rst_pin_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // Behavioural reference, advanced on every rising edge.
    int   m_dir, m_lat, m_rd;
    int   m_pipe[$];
    initial begin m_pipe.push_back(0); m_pipe.push_back(0); end

    always @(posedge clk) begin
        int older, port;
        older = m_pipe[0];
        if (rst) begin
            m_dir = 7; m_lat = 0; m_rd = 0;
            m_pipe.delete(); m_pipe.push_back(0); m_pipe.push_back(0);
        end else begin
            port = 0;
            for (int b = 0; b < 3; b++)
                if (older[b] && !ana_sel[b]) port += (1 << b);
            if (older[3] && !rst_pin_en) port += 8;
            if (dat_rd)      m_rd = port;
            else if (dir_rd) m_rd = 8 + m_dir;
            if (dat_wr) m_lat = bus_wdata % 8;
            if (dir_wr) m_dir = bus_wdata % 8;
            void'(m_pipe.pop_front());
            m_pipe.push_back(pad_in);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("R2 pad_oe vs model", pad_oe, 7 - m_dir);
            check("R3 pad_out vs model", pad_out, m_lat);
            check("R5 bus_rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        dat_wr = 0; dat_rd = 0; dir_wr = 0; dir_rd = 0;
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        // R1 reset state
        check("R1 oe after reset", pad_oe, 0);
        check("R1 out after reset", pad_out, 0);
        check("R1 rdata after reset", bus_rdata, 0);
        rst = 0;
        dir_rd = 1; step(); idle();
        check("R1 dir read after reset", bus_rdata, 8'h0F);

        // R10 / R7 direction write
        bus_wdata = 8'h02; dir_wr = 1; step(); idle();
        check("R10 oe after dir write", pad_oe, 4'b0101);
        dir_rd = 1; step(); idle();
        check("R10 R7 dir read", bus_rdata, 8'h0A);
        bus_wdata = 8'hF0; dir_wr = 1; step(); idle();
        dir_rd = 1; step(); idle();
        check("R7 top dir bit stays 1", bus_rdata, 8'h08);

        // R3 data write, upper bits ignored
        bus_wdata = 8'hFD; dat_wr = 1; step(); idle();
        check("R3 pad_out", pad_out, 4'b0101);

        // R4 synchronizer latency
        pad_in = 4'b1011; dat_rd = 1; step();
        check("R4 first edge old value", bus_rdata, 0);
        step();
        check("R4 second edge old value", bus_rdata, 0);
        step(); idle();
        check("R4 third edge new value", bus_rdata, 8'h0B);

        // R6 analog read-back zero, R9 drivers untouched
        ana_sel = 3'b011; dat_rd = 1; step(); idle();
        check("R6 analog pins read zero", bus_rdata, 8'h08);
        check("R9 oe unchanged by analog", pad_oe, 4'b0111);
        check("R9 out unchanged by analog", pad_out, 4'b0101);

        // R8 reset-pin enable
        rst_pin_en = 1; dat_rd = 1; step(); idle();
        check("R8 top bit zero", bus_rdata, 8'h00);
        ana_sel = 3'b000; dat_rd = 1; step(); idle();
        check("R8 low bits visible", bus_rdata, 8'h03);
        rst_pin_en = 0;

        // R5 priority and hold
        dat_rd = 1; dir_rd = 1; step(); idle();
        check("R5 data read wins", bus_rdata, 8'h0B);
        step(); step();
        check("R5 rdata holds", bus_rdata, 8'h0B);

        // Random phase against the reference
        for (int n = 0; n < 600; n++) begin
            bus_wdata  = 8'($urandom);
            dat_wr     = ($urandom % 4) == 0;
            dir_wr     = ($urandom % 4) == 0;
            dat_rd     = ($urandom % 3) == 0;
            dir_rd     = ($urandom % 3) == 0;
            ana_sel    = 3'($urandom);
            rst_pin_en = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) pad_in = 4'($urandom);
            if (n == 300) rst = 1;
            if (n == 302) rst = 0;
            step();
        end
        idle(); rst = 0; step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule